// File: doc/BRIEF.md
# PCM time slot interchanger

This block is a single-stage digital time switch for a frame of 32 slots carrying 8-bit samples. One sample enters on `sample_i` every clock, and each clock is one slot. A free-running slot counter numbers the slots 0 to 31 and wraps at the end of each frame. The sample for a given output slot leaves on `sample_o` one clock later, and `out_slot_o` tags which output slot it belongs to.

Two memories work together. The speech memory holds one sample per slot. The control memory holds one routing entry per slot, made of a valid bit and a 5-bit slot address. `mode_i` chooses how the control entries are used. In output-associated mode, writes go in slot order and the control entry of the current slot picks the read location. In input-associated mode, the control entry of the current slot picks the write location and reads go in slot order.

A host port loads a control entry to make a connection or clears it to drop one. A slot with no valid source carries the idle pattern 8'hFF.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted and right after it, `sample_o` is 8'hFF, and `slot_o` and `out_slot_o` are 0. Every control entry starts invalid, and every speech location holds 8'hFF with its valid flag clear.
- R2: `slot_o` advances by one on each clock and wraps from 31 to 0. `out_slot_o` equals the value `slot_o` had on the previous clock, and it names the output slot that `sample_o` is carrying.
- R3: In output-associated mode (`mode_i`=0), the input sample of slot n is written to speech location n. Output slot m carries speech location e, where e is the address field of valid control entry m. When e < m, this is the sample from the same frame, delayed by m-e slots (for example, 4 to 6 gives 2 slots).
- R4: In output-associated mode, when the source e is greater than or equal to the destination m, output slot m carries the sample of slot e from the previous frame. That is a delay of 32-(e-m) slots, and 32 slots when e = m.
- R5: In input-associated mode (`mode_i`=1), the input sample of slot n is written to speech location d, where d is the address of valid control entry n. This also sets the valid flag of location d. Output slot m carries speech location m if its flag is set. If a write to location d and the read of location d fall in the same slot, the read returns the old value and the flag ends up set.
- R6: In output-associated mode, an output slot whose control entry is invalid carries 8'hFF.
- R7: In input-associated mode, reading a location clears its flag. An output slot whose location has not been written since its last read carries 8'hFF, so a dropped connection sends no stale sample.
- R8: A host write (`cfg_we_i`) sets control entry `cfg_idx_i` to valid `cfg_valid_i` and address `cfg_addr_i`. Writing `cfg_valid_i`=0 erases the entry. The new entry takes effect from the next slot, and the slot that is in progress still uses the old entry.
- R9: A connection carries a fresh sample in every frame until its control entry is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 output-associated, 1 input-associated |
| sample_i | input | 8 | Input sample for slot `slot_o` |
| cfg_we_i | input | 1 | Host control entry write strobe |
| cfg_idx_i | input | 5 | Control entry index |
| cfg_valid_i | input | 1 | Valid bit to store (0 erases) |
| cfg_addr_i | input | 5 | Slot address to store |
| slot_o | output | 5 | Current slot number |
| sample_o | output | 8 | Switched output sample |
| out_slot_o | output | 5 | Output slot carried on `sample_o` |

## Verification
Each slot gets a random sample, so any wrong routing or wrong frame shows up as a data mismatch. The routes place the source before, after and on the destination slot, which separates the same-frame path from the previous-frame path in output-associated mode. In input-associated mode, routes that share a destination, and routes whose destination matches or precedes the source slot, test the flag handling and the priority between a write and a read in the same slot. Further cases cover host writes to the slot in progress, erasing routes in the middle of a call, and switching modes, which show whether stale samples are suppressed and whether entries are applied at the right slot.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {
    MODE_OUT_ASSOC = 1'b0,
    MODE_IN_ASSOC  = 1'b1
  } tsi_mode_e;

  localparam logic [7:0] TSI_IDLE_DEF = 8'hFF;
endpackage

// File: rtl/tsi_slot_cnt.sv
module tsi_slot_cnt #(
  parameter int SLOTS = 32,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] slot_o
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_o <= '0;
    else if (slot_o == LAST) slot_o <= '0;
    else                     slot_o <= slot_o + 1'b1;
  end
endmodule

// File: rtl/tsi_ctrl_mem.sv
module tsi_ctrl_mem #(
  parameter int SLOTS = 32,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic          wvalid_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] ridx_i,
  output logic          rvalid_o,
  output logic [AW-1:0] raddr_o
);
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [AW-1:0]    adr_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_ent
    assign vld_d[i] = (we_i && widx_i == AW'(i)) ? wvalid_i : vld_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < SLOTS; i++) adr_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      if (we_i) adr_q[widx_i] <= waddr_i;
    end
  end

  // read sees pre-edge contents: host write lands at next slot
  assign rvalid_o = vld_q[ridx_i];
  assign raddr_o  = adr_q[ridx_i];
endmodule

// File: rtl/tsi_speech_mem.sv
module tsi_speech_mem #(
  parameter int         SLOTS = 32,
  parameter int         W     = 8,
  parameter logic [W-1:0] IDLE = '1,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             set_flag_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [AW-1:0]    clr_idx_i,
  output logic [W-1:0]     rd_data_o,
  output logic [SLOTS-1:0] flag_o
);
  logic [W-1:0]     mem_q [SLOTS];
  logic [SLOTS-1:0] flag_d;

  for (genvar i = 0; i < SLOTS; i++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set   = wr_en_i && set_flag_i && wr_addr_i == AW'(i);
    assign hit_clr   = clr_idx_i == AW'(i);
    // set wins over clear in the same slot
    assign flag_d[i] = hit_set | (flag_o[i] & ~hit_clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= '0;
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= IDLE;
    end else begin
      flag_o <= flag_d;
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int           SLOTS = 32,
  parameter int           W     = 8,
  parameter logic [W-1:0] IDLE  = tsi_pkg::TSI_IDLE_DEF,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [W-1:0]  sample_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_idx_i,
  input  logic          cfg_valid_i,
  input  logic [AW-1:0] cfg_addr_i,
  output logic [AW-1:0] slot_o,
  output logic [W-1:0]  sample_o,
  output logic [AW-1:0] out_slot_o
);
  import tsi_pkg::*;

  tsi_mode_e        mode;
  logic             ent_valid;
  logic [AW-1:0]    ent_addr;
  logic             sp_wr_en;
  logic [AW-1:0]    sp_wr_addr;
  logic [AW-1:0]    sp_rd_addr;
  logic [W-1:0]     sp_rd_data;
  logic [SLOTS-1:0] sp_flag;
  logic             rd_hit;

  assign mode = tsi_mode_e'(mode_i);

  tsi_slot_cnt #(.SLOTS(SLOTS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot_o)
  );

  tsi_ctrl_mem #(.SLOTS(SLOTS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .widx_i   (cfg_idx_i),
    .wvalid_i (cfg_valid_i),
    .waddr_i  (cfg_addr_i),
    .ridx_i   (slot_o),
    .rvalid_o (ent_valid),
    .raddr_o  (ent_addr)
  );

  always_comb begin
    if (mode == MODE_OUT_ASSOC) begin
      sp_wr_en   = 1'b1;
      sp_wr_addr = slot_o;
      sp_rd_addr = ent_addr;
      rd_hit     = ent_valid;
    end else begin
      sp_wr_en   = ent_valid;
      sp_wr_addr = ent_addr;
      sp_rd_addr = slot_o;
      rd_hit     = sp_flag[slot_o];
    end
  end

  tsi_speech_mem #(.SLOTS(SLOTS), .W(W), .IDLE(IDLE)) u_speech (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (sp_wr_en),
    .wr_addr_i  (sp_wr_addr),
    .wr_data_i  (sample_i),
    .set_flag_i (mode == MODE_IN_ASSOC),
    .rd_addr_i  (sp_rd_addr),
    .clr_idx_i  (slot_o),
    .rd_data_o  (sp_rd_data),
    .flag_o     (sp_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o   <= IDLE;
      out_slot_o <= '0;
    end else begin
      sample_o   <= rd_hit ? sp_rd_data : IDLE;
      out_slot_o <= slot_o;
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int           SLOTS = 32,
  parameter int           W     = 8,
  parameter logic [W-1:0] IDLE  = '1,
  localparam int AW = $clog2(SLOTS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic [AW-1:0]    slot_o,
  input logic [AW-1:0]    out_slot_o,
  input logic [W-1:0]     sample_o,
  input logic             rd_hit,
  input logic             sp_wr_en,
  input logic [AW-1:0]    sp_wr_addr,
  input logic [SLOTS-1:0] sp_flag
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  logic          prev_chk;
  logic [AW-1:0] prev_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_chk  <= 1'b0;
      prev_slot <= '0;
    end else begin
      prev_chk  <= !(mode_i && sp_wr_en && sp_wr_addr == slot_o);
      prev_slot <= slot_o;
    end
  end

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o == LAST |=> slot_o == '0); // R2
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o != LAST |=> slot_o == $past(slot_o) + 1'b1); // R2
  AST_OUT_SLOT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_slot_o == $past(slot_o)); // R2
  AST_SEQ_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> sp_wr_en && sp_wr_addr == slot_o); // R3
  AST_IDLE_NO_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> sample_o == IDLE); // R6
  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_chk |-> !sp_flag[prev_slot]); // R7
endmodule

bind tsi_switch tsi_switch_chk #(.SLOTS(SLOTS), .W(W), .IDLE(IDLE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .slot_o     (slot_o),
  .out_slot_o (out_slot_o),
  .sample_o   (sample_o),
  .rd_hit     (rd_hit),
  .sp_wr_en   (sp_wr_en),
  .sp_wr_addr (sp_wr_addr),
  .sp_flag    (sp_flag)
);

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;
  localparam int SLOTS = 32;
  localparam int W = 8;
  localparam int AW = 5;
  localparam logic [W-1:0] IDLE = 8'hFF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic cfg_we_i = 1'b0, cfg_valid_i = 1'b0;
  logic [AW-1:0] cfg_idx_i = '0, cfg_addr_i = '0;
  logic [AW-1:0] slot_o, out_slot_o;
  logic [W-1:0] sample_o;

  always #2.5 clk = ~clk;

  tsi_switch u_tsi_switch (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .sample_i(sample_i),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_valid_i(cfg_valid_i),
    .cfg_addr_i(cfg_addr_i), .slot_o(slot_o), .sample_o(sample_o),
    .out_slot_o(out_slot_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // requirement-level model state
  logic         m_v  [SLOTS];
  logic [AW-1:0] m_a [SLOTS];
  logic [W-1:0] m_sp [SLOTS];
  logic         m_fl [SLOTS];
  int m_slot;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) begin
      m_v[i] = 0; m_a[i] = '0; m_sp[i] = IDLE; m_fl[i] = 0;
    end
    m_slot = 0;
  endtask

  // drive one slot at negedge, predict, check after the edge
  task automatic step(logic md, logic [W-1:0] smp, logic we, logic [AW-1:0] idx,
                      logic vl, logic [AW-1:0] ad);
    logic [W-1:0] exp;
    string tag;
    int oslot;
    mode_i = md; sample_i = smp; cfg_we_i = we; cfg_idx_i = idx;
    cfg_valid_i = vl; cfg_addr_i = ad;
    oslot = m_slot;
    if (!md) begin
      if (m_v[m_slot]) begin
        exp = m_sp[m_a[m_slot]];
        tag = (int'(m_a[m_slot]) < m_slot) ? "R3/R9" : "R4";
      end else begin
        exp = IDLE; tag = "R6";
      end
    end else begin
      if (m_fl[m_slot]) begin exp = m_sp[m_slot]; tag = "R5"; end
      else begin exp = IDLE; tag = "R7"; end
    end
    if (we && int'(idx) == m_slot) tag = "R8";
    m_fl[m_slot] = 0;
    if (!md) m_sp[m_slot] = smp;
    else if (m_v[m_slot]) begin
      m_sp[m_a[m_slot]] = smp;
      m_fl[m_a[m_slot]] = 1;
    end
    if (we) begin m_v[idx] = vl; m_a[idx] = ad; end
    m_slot = (m_slot + 1) % SLOTS;
    @(posedge clk);
    @(negedge clk);
    check(tag, sample_o, exp);
    check("R2", out_slot_o, oslot);
    check("R2", slot_o, m_slot);
  endtask

  task automatic idle_slot(logic md);
    step(md, W'($urandom), 1'b0, '0, 1'b0, '0);
  endtask

  task automatic cfg_slot(logic md, int idx, logic vl, int ad);
    step(md, W'($urandom), 1'b1, AW'(idx), vl, AW'(ad));
  endtask

  task automatic run_frames(logic md, int n);
    for (int i = 0; i < n * SLOTS; i++) idle_slot(md);
  endtask

  task automatic rand_frames(logic md, int n);
    for (int i = 0; i < n * SLOTS; i++)
      step(md, W'($urandom), ($urandom % 6) == 0, AW'($urandom),
           ($urandom % 4) != 0, AW'($urandom));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", sample_o, IDLE);
    check("R1", slot_o, 0);
    check("R1", out_slot_o, 0);
    rst_ni = 1'b1;
    // R1/R6: no routes after reset, every slot idle
    run_frames(1'b0, 1);
    // R3 R9: slot 4 to slot 6, repeated every frame
    cfg_slot(1'b0, 6, 1'b1, 4);
    // R4: later source and equal source
    cfg_slot(1'b0, 2, 1'b1, 20);
    cfg_slot(1'b0, 7, 1'b1, 7);
    run_frames(1'b0, 3);
    // R8: write entry of the slot in progress
    while (m_slot != 10) idle_slot(1'b0);
    cfg_slot(1'b0, 10, 1'b1, 3);
    run_frames(1'b0, 1);
    rand_frames(1'b0, 8);
    // R6: erase all entries
    for (int i = 0; i < SLOTS; i++) cfg_slot(1'b0, i, 1'b0, 0);
    run_frames(1'b0, 1);
    // R5: input-associated, forward, backward and same-slot routes
    cfg_slot(1'b1, 3, 1'b1, 9);
    cfg_slot(1'b1, 12, 1'b1, 5);
    cfg_slot(1'b1, 14, 1'b1, 14);
    run_frames(1'b1, 3);
    // R7: drop route, no stale replay
    while (m_slot != 20) idle_slot(1'b1);
    cfg_slot(1'b1, 3, 1'b0, 0);
    cfg_slot(1'b1, 12, 1'b0, 0);
    run_frames(1'b1, 2);
    rand_frames(1'b1, 8);
    // mode switching with live routes
    for (int f = 0; f < 4; f++) rand_frames(f[0], 1);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule